// File: doc/BRIEF.md
# ADC Command Queue Sequencer

This block sits between a command FIFO and the command port of an analog converter. It takes 32-bit command words from the FIFO and forwards them, one per handshake, to the converter side. Each command word carries a small header, and two of its bits steer the block. One bit marks the last command of a queue. The other bit asks the queue to stop and wait for a new trigger before it sends more commands. In this way one queue can be split into sub-queues, and each sub-queue starts on its own trigger edge.

A queue is started in one of three ways. Software selects a mode and pulses an arm input. In the two edge modes the queue then waits for a rising edge on the trigger input. In the software mode it starts at once. In single-scan modes the queue stops after its last command until it is armed again. In continuous-scan mode it goes back to waiting for the next trigger edge. A transfer counter gives the position within the current queue. Two sticky flags record that a last-of-queue command or a pause command has been sent. Software clears each flag by writing 1 to its clear input.

Both data paths use valid/ready. The block adds no storage: a command passes straight from the FIFO side to the converter side when the queue is triggered. Back-pressure from the converter reaches the FIFO in the same cycle. While the queue is not triggered, the block holds `cmd_ready_o` and `out_valid_o` low, whatever the FIFO offers. A command is transferred in the cycle where `out_valid_o` and `out_ready_i` are both high.

Top module: `cmdq_seq`

## Requirements
- R1: Command bits are numbered from the MSB, bit 0 being data[31]. data[31] is end-of-queue, data[30] is pause and data[26] is read/write. With data[26]=1 the command is a read: `out_expect_rsp_o`=1 and `out_is_write_o`=0. With data[26]=0 the command is a write-configuration command: `out_expect_rsp_o`=0 and `out_is_write_o`=1. For a write-configuration command, `out_reg_addr_o` is data[7:0] and `out_reg_value_o` is {data[23:16] (high byte), data[15:8] (low byte)}. `out_data_o` equals the command word.
- R2: Commands move only in state TRIGGERED (`state_o`=2). In that state `out_valid_o` follows `cmd_valid_i` and `cmd_ready_o` follows `out_ready_i`. In any other state both are 0. When the FIFO is empty, or the converter holds ready low, no command moves and neither the state nor the counter changes.
- R3: Each transfer whose end-of-queue bit is clear adds one to `tc_o`.
- R4: A transfer whose end-of-queue bit is set loads `tc_o` with 0.
- R5: In mode 1 (single-scan, edge) or mode 2 (continuous-scan, edge), a transfer with the pause bit set and the end-of-queue bit clear moves the state to WAITING_FOR_TRIGGER (`state_o`=1). The next rising edge on `trig_i` moves it back to TRIGGERED.
- R6: In mode 3 (single-scan, software start) the pause bit leaves the state in TRIGGERED.
- R7: When end-of-queue and pause are both set in one command, both flags are set. The state then changes as if only end-of-queue were set.
- R8: After an end-of-queue transfer, modes 1 and 3 go to IDLE (`state_o`=0) and mode 2 goes to WAITING_FOR_TRIGGER.
- R9: An `arm_i` pulse in IDLE moves to WAITING_FOR_TRIGGER in modes 1 and 2 and to TRIGGERED in mode 3. In mode 0 (off) the pulse is ignored.
- R10: A rising edge on `trig_i` has no effect unless the state is WAITING_FOR_TRIGGER.
- R11: `eoq_flag_o` and `pause_flag_o` are set by a transfer that carries the matching bit. Each stays set until its clear input is 1. If a set and a clear fall in the same cycle, the set wins.
- R12: After reset the state is IDLE, `tc_o` is 0 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0 off, 1 single-scan edge, 2 continuous-scan edge, 3 single-scan software start |
| arm_i | input | 1 | Software start pulse |
| trig_i | input | 1 | Trigger input; rising edges count |
| cmd_valid_i | input | 1 | FIFO has a command |
| cmd_data_i | input | 32 | Command word from FIFO |
| cmd_ready_o | output | 1 | Command taken this cycle if valid |
| out_valid_o | output | 1 | Command offered to converter |
| out_ready_i | input | 1 | Converter accepts a command |
| out_data_o | output | 32 | Command word to converter |
| out_expect_rsp_o | output | 1 | Command is a read; one result word follows |
| out_is_write_o | output | 1 | Command is a write-configuration command |
| out_reg_addr_o | output | 8 | Target register address of a write |
| out_reg_value_o | output | 16 | Register value of a write, high byte first |
| state_o | output | 2 | 0 IDLE, 1 WAITING_FOR_TRIGGER, 2 TRIGGERED |
| tc_o | output | 8 | Transfer counter |
| eoq_flag_o | output | 1 | End-of-queue flag |
| pause_flag_o | output | 1 | Pause flag |
| clr_eoq_i | input | 1 | Write-1 clear of end-of-queue flag |
| clr_pause_i | input | 1 | Write-1 clear of pause flag |

## Verification
On every cycle the assertions check the following. The counter either holds, steps by one, or drops to zero, each exactly as the transfer and its end-of-queue bit require. Pause moves the state to waiting only in the edge modes. A waiting queue stays put until a trigger edge, and an idle queue stays put until armed. A flag set by a transfer is visible in the next cycle. The bench scenarios cover the rest. These are the field decode of read and write commands, checked by the scoreboard against each forwarded word. They also cover the state chosen after end-of-queue in each mode, the priority of end-of-queue over pause, arming in all four modes, a trigger edge that arrives while already triggered, and a flag clear that lands in the same cycle as a set.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int CMD_W     = 32;
  localparam int EOQ_POS   = 31;
  localparam int PAUSE_POS = 30;
  localparam int RD_POS    = 26;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_TRIG = 2'd2
  } qstate_e;

  typedef enum logic [1:0] {
    MD_OFF         = 2'd0,
    MD_SINGLE_EDGE = 2'd1,
    MD_CONT_EDGE   = 2'd2,
    MD_SINGLE_SW   = 2'd3
  } qmode_e;

  typedef struct packed {
    logic        eoq;
    logic        pause;
    logic        is_read;
    logic [7:0]  addr;
    logic [15:0] value;
  } cmd_hdr_t;

  function automatic logic edge_mode(input qmode_e m);
    return (m == MD_SINGLE_EDGE) || (m == MD_CONT_EDGE);
  endfunction
endpackage

// File: rtl/cmdq_decode.sv
module cmdq_decode
  import cmdq_pkg::*;
(
  input  logic [CMD_W-1:0] word_i,
  output cmd_hdr_t         hdr_o
);
  logic unused_bits;
  assign unused_bits = ^{word_i[29:27], word_i[25:24]};

  always_comb begin
    hdr_o.eoq     = word_i[EOQ_POS];
    hdr_o.pause   = word_i[PAUSE_POS];
    hdr_o.is_read = word_i[RD_POS];
    hdr_o.addr    = word_i[7:0];
    hdr_o.value   = {word_i[23:16], word_i[15:8]};
  end
endmodule

// File: rtl/cmdq_fsm.sv
module cmdq_fsm
  import cmdq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  qmode_e  mode_i,
  input  logic    arm_i,
  input  logic    trig_i,
  input  logic    xfer_i,
  input  logic    eoq_i,
  input  logic    pause_i,
  output qstate_e state_o
);
  qstate_e state_q, state_d;
  logic    trig_q;
  logic    trig_edge;

  assign trig_edge = trig_i & ~trig_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (arm_i) begin
        if (edge_mode(mode_i))          state_d = ST_WAIT;
        else if (mode_i == MD_SINGLE_SW) state_d = ST_TRIG;
      end
      ST_WAIT: if (trig_edge) state_d = ST_TRIG;
      ST_TRIG: if (xfer_i) begin
        if (eoq_i)
          state_d = (mode_i == MD_CONT_EDGE) ? ST_WAIT : ST_IDLE;
        else if (pause_i && edge_mode(mode_i))
          state_d = ST_WAIT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      trig_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      trig_q  <= trig_i;
    end
  end

  assign state_o = state_q;

  // R5: pause in an edge mode parks the queue
  a_r5_pause_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRIG && xfer_i && pause_i && !eoq_i && edge_mode(mode_i))
      |=> state_q == ST_WAIT);
  // R6: software mode ignores pause
  a_r6_pause_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRIG && xfer_i && !eoq_i && mode_i == MD_SINGLE_SW)
      |=> state_q == ST_TRIG);
  // R10: waiting holds until a trigger edge
  a_r10_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !(trig_i && !trig_q)) |=> state_q == ST_WAIT);
  // R9/R10: idle holds until armed
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !arm_i) |=> state_q == ST_IDLE);
endmodule

// File: rtl/cmdq_tc.sv
module cmdq_tc #(
  parameter int TC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer_i,
  input  logic            eoq_i,
  output logic [TC_W-1:0] tc_o
);
  localparam logic [TC_W-1:0] ONE = TC_W'(1);

  logic [TC_W-1:0] tc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tc_q <= '0;
    else if (xfer_i) tc_q <= eoq_i ? '0 : tc_q + ONE;
  end

  assign tc_o = tc_q;

  // R4: end-of-queue clears the counter
  a_r4_eoq_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && eoq_i) |=> tc_q == '0);
  // R3: a plain transfer steps by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && !eoq_i) |=> tc_q == $past(tc_q) + ONE);
  // R2: no transfer, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_i |=> $stable(tc_q));
endmodule

// File: rtl/cmdq_flags.sv
module cmdq_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  output logic [NFLAG-1:0] flag_o
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
      else if (clr_i[g]) q <= 1'b0;
    end
    assign flag_o[g] = q;

    // R11: a set is seen next cycle, even against a clear
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> q);
    // R11: sticky without a clear
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr_i[g]) |=> q);
  end
endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
  import cmdq_pkg::*;
#(
  parameter int TC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             arm_i,
  input  logic             trig_i,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_data_i,
  output logic             cmd_ready_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [CMD_W-1:0] out_data_o,
  output logic             out_expect_rsp_o,
  output logic             out_is_write_o,
  output logic [7:0]       out_reg_addr_o,
  output logic [15:0]      out_reg_value_o,
  output logic [1:0]       state_o,
  output logic [TC_W-1:0]  tc_o,
  output logic             eoq_flag_o,
  output logic             pause_flag_o,
  input  logic             clr_eoq_i,
  input  logic             clr_pause_i
);
  localparam int NFLAG = 2;

  cmd_hdr_t         hdr;
  qstate_e          state;
  logic             live;
  logic             xfer;
  logic [NFLAG-1:0] flags;

  cmdq_decode u_dec (.word_i(cmd_data_i), .hdr_o(hdr));

  assign live        = (state == ST_TRIG);
  assign out_valid_o = cmd_valid_i & live;
  assign cmd_ready_o = out_ready_i & live;
  assign xfer        = out_valid_o & out_ready_i;

  assign out_data_o       = cmd_data_i;
  assign out_expect_rsp_o = hdr.is_read;
  assign out_is_write_o   = ~hdr.is_read;
  assign out_reg_addr_o   = hdr.addr;
  assign out_reg_value_o  = hdr.value;

  cmdq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .mode_i(qmode_e'(mode_i)), .arm_i(arm_i),
    .trig_i(trig_i), .xfer_i(xfer), .eoq_i(hdr.eoq), .pause_i(hdr.pause),
    .state_o(state)
  );

  cmdq_tc #(.TC_W(TC_W)) u_tc (
    .clk(clk), .rst_n(rst_n), .xfer_i(xfer), .eoq_i(hdr.eoq), .tc_o(tc_o)
  );

  cmdq_flags #(.NFLAG(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_i({xfer & hdr.pause, xfer & hdr.eoq}),
    .clr_i({clr_pause_i, clr_eoq_i}),
    .flag_o(flags)
  );

  assign eoq_flag_o   = flags[0];
  assign pause_flag_o = flags[1];
  assign state_o      = state;

  // R2: an empty FIFO leaves a triggered queue triggered
  a_r2_stall_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRIG && !cmd_valid_i) |=> state == ST_TRIG);
  // R8: continuous scan re-waits after end-of-queue
  a_r8_cont_rewait: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o && hdr.eoq && mode_i == 2'd2) |=> state == ST_WAIT);
endmodule

// File: tb/cmdq_seq_bench.sv
module cmdq_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        arm = 1'b0, trig = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_data = '0;
  logic        cmd_ready, out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_exp_rsp, out_is_wr;
  logic [7:0]  out_addr;
  logic [15:0] out_value;
  logic [1:0]  state;
  logic [7:0]  tc;
  logic        eoq_f, pause_f;
  logic        clr_eoq = 1'b0, clr_pause = 1'b0;

  int total = 0;
  int bad = 0;
  logic [31:0] sb_q[$];

  always #2 clk = ~clk;

  cmdq_seq u_cmdq_seq (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .arm_i(arm), .trig_i(trig),
    .cmd_valid_i(cmd_valid), .cmd_data_i(cmd_data), .cmd_ready_o(cmd_ready),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_expect_rsp_o(out_exp_rsp), .out_is_write_o(out_is_wr),
    .out_reg_addr_o(out_addr), .out_reg_value_o(out_value),
    .state_o(state), .tc_o(tc), .eoq_flag_o(eoq_f), .pause_flag_o(pause_f),
    .clr_eoq_i(clr_eoq), .clr_pause_i(clr_pause)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic e, input logic p, input logic rd,
                                     input logic [7:0] hi, input logic [7:0] lo,
                                     input logic [7:0] ad);
    return {e, p, 3'b000, rd, 2'b00, hi, lo, ad};
  endfunction

  // monitor: pop expected word on each forwarded command (R1, R2)
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2: actual=unexpected transfer %0h expected=none", out_data);
      end else begin
        logic [31:0] e;
        e = sb_q.pop_front();
        check("R1 word", out_data, e);
        check("R1 read", {31'b0, out_exp_rsp}, {31'b0, e[26]});
        check("R1 write", {31'b0, out_is_wr}, {31'b0, ~e[26]});
        if (!e[26]) begin
          check("R1 addr", {24'b0, out_addr}, {24'b0, e[7:0]});
          check("R1 value", {16'b0, out_value}, {16'b0, e[23:16], e[15:8]});
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push_cmd(input logic [31:0] w, input logic ce);
    sb_q.push_back(w);
    cmd_valid = 1'b1; cmd_data = w; clr_eoq = ce;
    do @(negedge clk); while (!cmd_ready);
    tick();
    cmd_valid = 1'b0; clr_eoq = 1'b0;
  endtask

  task automatic pulse_arm();
    arm = 1'b1; tick(); arm = 1'b0;
  endtask

  task automatic pulse_trig();
    trig = 1'b1; tick(); trig = 1'b0; tick();
  endtask

  task automatic clear_flags();
    clr_eoq = 1'b1; clr_pause = 1'b1; tick(); clr_eoq = 1'b0; clr_pause = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    // R12 reset state, R2 nothing moves while idle
    cmd_valid = 1'b1; cmd_data = 32'h1234_5678;
    #1;
    check("R12 state", {30'b0, state}, 0);
    check("R12 tc", {24'b0, tc}, 0);
    check("R12 flags", {30'b0, eoq_f, pause_f}, 0);
    check("R2 idle ready", {31'b0, cmd_ready}, 0);
    rst_n = 1'b1;
    tick();
    check("R2 idle valid", {31'b0, out_valid}, 0);
    cmd_valid = 1'b0;

    // R10 trigger in idle ignored
    pulse_trig();
    check("R10 idle trig", {30'b0, state}, 0);

    // R9 arm in single edge mode
    mode = 2'd1; pulse_arm();
    check("R9 arm edge", {30'b0, state}, 1);
    cmd_valid = 1'b1; cmd_data = 32'hDEAD_BEEF; #1;
    check("R2 wait blocks", {30'b0, out_valid, cmd_ready}, 0);
    tick();
    check("R2 wait holds", {30'b0, state}, 1);
    cmd_valid = 1'b0;
    pulse_trig();
    check("R5 trig starts", {30'b0, state}, 2);

    // R1/R3 write then read
    push_cmd(mk(0, 0, 0, 8'hAB, 8'hCD, 8'h12), 1'b0);
    check("R3 tc1", {24'b0, tc}, 1);
    push_cmd(mk(0, 0, 1, 8'h00, 8'h00, 8'h00), 1'b0);
    check("R3 tc2", {24'b0, tc}, 2);

    // R2 back-pressure
    out_ready = 1'b0; cmd_valid = 1'b1; cmd_data = 32'h0000_0001; #1;
    check("R2 bp ready", {31'b0, cmd_ready}, 0);
    check("R2 bp valid", {31'b0, out_valid}, 1);
    tick();
    check("R2 bp tc", {24'b0, tc}, 2);
    cmd_valid = 1'b0; out_ready = 1'b1;
    // R2 empty FIFO stall
    tick(); tick(); tick();
    check("R2 stall state", {30'b0, state}, 2);
    check("R2 stall tc", {24'b0, tc}, 2);

    // R10 trigger while triggered
    pulse_trig();
    check("R10 trig in trig", {30'b0, state}, 2);

    // R5 pause
    push_cmd(mk(0, 1, 0, 8'h01, 8'h02, 8'h34), 1'b0);
    check("R5 pause state", {30'b0, state}, 1);
    check("R11 pause flag", {31'b0, pause_f}, 1);
    check("R3 tc3", {24'b0, tc}, 3);
    pulse_trig();
    check("R5 resume", {30'b0, state}, 2);

    // R4/R8 end of queue in single mode
    push_cmd(mk(1, 0, 1, 8'h00, 8'h00, 8'h00), 1'b0);
    check("R4 tc zero", {24'b0, tc}, 0);
    check("R8 single idle", {30'b0, state}, 0);
    check("R11 eoq flag", {31'b0, eoq_f}, 1);

    // R11 write-one clear
    clr_pause = 1'b1; tick(); clr_pause = 1'b0;
    check("R11 clr pause", {30'b0, eoq_f, pause_f}, 2);
    clear_flags();
    check("R11 clr both", {30'b0, eoq_f, pause_f}, 0);

    // R8 continuous, R11 set wins over clear
    mode = 2'd2; pulse_arm();
    check("R9 arm cont", {30'b0, state}, 1);
    pulse_trig();
    push_cmd(mk(0, 0, 0, 8'h55, 8'h66, 8'h77), 1'b0);
    check("R3 cont tc", {24'b0, tc}, 1);
    push_cmd(mk(1, 0, 0, 8'h11, 8'h22, 8'h33), 1'b1);
    check("R11 set wins", {31'b0, eoq_f}, 1);
    check("R8 cont wait", {30'b0, state}, 1);
    check("R4 cont tc", {24'b0, tc}, 0);
    clear_flags();

    // R7 eoq and pause together in single mode
    mode = 2'd1; pulse_trig();
    check("R7 trig", {30'b0, state}, 2);
    push_cmd(mk(1, 1, 1, 8'h00, 8'h00, 8'h00), 1'b0);
    check("R7 state", {30'b0, state}, 0);
    check("R7 flags", {30'b0, eoq_f, pause_f}, 3);
    clear_flags();

    // R9/R6 software mode
    mode = 2'd3; pulse_arm();
    check("R9 arm sw", {30'b0, state}, 2);
    push_cmd(mk(0, 1, 0, 8'h9A, 8'hBC, 8'hDE), 1'b0);
    check("R6 pause ignored", {30'b0, state}, 2);
    check("R6 tc", {24'b0, tc}, 1);
    push_cmd(mk(1, 0, 0, 8'h00, 8'h00, 8'h01), 1'b0);
    check("R8 sw idle", {30'b0, state}, 0);

    // R9 mode off ignores arm
    mode = 2'd0; pulse_arm();
    check("R9 arm off", {30'b0, state}, 0);
    check("R2 sb drained", sb_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule